// File: doc/BRIEF.md
# Serial Configuration Port for a Four-Channel Device

This block is a serial slave that gives a host access to a small set of 8-bit command registers belonging to a four-channel device. The host lowers an active-low select, toggles a serial clock, shifts a header and a data byte in on one wire, and on reads receives a byte back on a second wire. Each channel owns one writable configuration register and one read-only status register. The configuration bits leave the block as parallel outputs, and the status bits arrive as parallel inputs.

The serial clock, select and data lines are brought into a faster system clock domain through two-stage synchronizers. Edges of the serial clock are detected in that domain, so the serial clock must be several times slower than the system clock. Every 16-bit frame is laid out LSB first:

| Bit | Meaning |
|-----|---------|
| 0 | direction (1 = read, 0 = write) |
| 1..5 | register address A0..A4 |
| 6 | enable bit, must be zero to reach a register |
| 7 | don't-care |
| 8..15 | data D0..D7 |

Top module: `serial_cfg_port`

## Requirements
- R1: After reset all configuration outputs are 0 and `sdo_oe` is low.
- R2: On each rising serial clock edge with select active, frame bit k is sampled in order. Bit 0 is the direction flag, with 1 meaning read and 0 meaning write. Bits 1..5 are address A0..A4. Bit 6 must be 0 to reach a register. Bit 7 has no effect.
- R3: On a write, frame bits 8..15 carry D0..D7. Address {ch,3'b110} (0x06, 0x0E, 0x16, 0x1E for ch 0..3) loads D5..D0 into `cfg_out[ch*6 +: 6]` once the sixteenth bit has been sampled.
- R4: On a read, `sdo_oe` is low through the first eight bits. D0 appears on `sdo` after the falling edge that follows the eighth rising edge. Each later falling edge presents the next bit, so each bit is valid at the following rising edge.
- R5: Reading a configuration register returns its six stored bits in D5..D0 and zeros in D7..D6.
- R6: Reading address {ch,3'b111} (0x07, 0x0F, 0x17, 0x1F) returns `status_in[ch]` in D0 and zeros elsewhere. That value is captured when the eighth header bit is sampled, so later changes on `status_in` do not affect the byte being shifted out.
- R7: Reads of addresses whose low three bits are neither 110 nor 111 return 0.
- R8: Writes to status or unmapped addresses, and any access with bit 6 set, leave every configuration register unchanged. A read with bit 6 set returns 0.
- R9: Deasserting select aborts the transaction. The bit position returns to idle, `sdo_oe` goes low, and a write that has not yet received all 16 bits is discarded. This includes the case where the deassertion is seen in the same system clock cycle as the sixteenth rising edge.
- R10: Serial clock edges after the sixteenth bit, while select stays active, change no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Active-low serial select |
| sclk | input | 1 | Serial clock, much slower than clk |
| sdi | input | 1 | Serial data from host |
| status_in | input | 4 | Per-channel status flag |
| sdo | output | 1 | Serial data to host |
| sdo_oe | output | 1 | High when `sdo` should be driven |
| cfg_out | output | 24 | Six configuration bits per channel, channel 0 in the low bits |

## Verification
The commit of a write and an abort by select can land in the same system clock cycle. This happens when the host raises the serial clock for the sixteenth bit at the same instant that it releases select. The bench provokes this by changing both lines in one time step, so that both synchronizers see the change together. It judges the outcome by checking that `cfg_out` still holds the prior value and that a following readback agrees. A second overlap is exercised as well: `status_in` is inverted while a status byte is being shifted out. The returned byte must match the value captured when the header completed.

// File: rtl/serial_cfg_port.sv
module serial_cfg_port #(
  parameter int NCH    = 4,
  parameter int CFG_W  = 6,
  parameter int DATA_W = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   cs_n,
  input  logic                   sclk,
  input  logic                   sdi,
  input  logic [NCH-1:0]         status_in,
  output logic                   sdo,
  output logic                   sdo_oe,
  output logic [NCH*CFG_W-1:0]   cfg_out
);
  localparam int FRAME = 2 * DATA_W;
  localparam int CW    = $clog2(FRAME + 1);
  localparam int CHB   = $clog2(NCH);

  logic [2:0] sclk_s;
  logic [1:0] cs_s, sdi_s;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sclk_s <= '0;
      cs_s   <= '1;
      sdi_s  <= '0;
    end else begin
      sclk_s <= {sclk_s[1:0], sclk};
      cs_s   <= {cs_s[0], cs_n};
      sdi_s  <= {sdi_s[0], sdi};
    end

  wire rise   = sclk_s[1] & ~sclk_s[2];
  wire fall   = ~sclk_s[1] & sclk_s[2];
  wire cs_act = ~cs_s[1];
  wire din    = sdi_s[1];

  logic [CW-1:0]          cnt;
  logic                   rw_q, a5_q, sdo_q, oe_q;
  logic [4:0]             addr_q;
  logic [DATA_W-1:0]      wsh, rsh, rdata;
  logic [NCH*CFG_W-1:0]   cfg_q;

  wire [CHB-1:0]     ch     = addr_q[3 +: CHB];
  wire               is_cfg = ~a5_q & (addr_q[2:0] == 3'b110);
  wire               is_st  = ~a5_q & (addr_q[2:0] == 3'b111);
  wire [DATA_W-1:0]  wfull  = {din, wsh[DATA_W-1:1]};

  always_comb begin
    rdata = '0;
    if (is_cfg)     rdata[CFG_W-1:0] = cfg_q[ch*CFG_W +: CFG_W];
    else if (is_st) rdata[0]         = status_in[ch];
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      cnt    <= '0;
      rw_q   <= 1'b0;
      a5_q   <= 1'b0;
      addr_q <= '0;
      wsh    <= '0;
      rsh    <= '0;
      sdo_q  <= 1'b0;
      oe_q   <= 1'b0;
      cfg_q  <= '0;
    end else if (!cs_act) begin
      cnt   <= '0;
      oe_q  <= 1'b0;
      sdo_q <= 1'b0;
    end else begin
      if (rise && cnt != CW'(FRAME)) begin
        cnt <= cnt + 1'b1;
        if (cnt == 0) rw_q <= din;
        else if (cnt <= 5) addr_q[cnt[2:0] - 3'd1] <= din;
        else if (cnt == 6) a5_q <= din;
        else if (cnt == 7) rsh <= rdata;
        else begin
          wsh <= wfull;
          if (cnt == CW'(FRAME - 1) && !rw_q && is_cfg)
            cfg_q[ch*CFG_W +: CFG_W] <= wfull[CFG_W-1:0];
        end
      end
      if (fall && rw_q && cnt >= CW'(DATA_W) && cnt < CW'(FRAME)) begin
        oe_q  <= 1'b1;
        sdo_q <= rsh[0];
        rsh   <= rsh >> 1;
      end
    end

  assign sdo     = sdo_q;
  assign sdo_oe  = oe_q;
  assign cfg_out = cfg_q;

  AST_OE_DROP: assert property (@(posedge clk) disable iff (!rst_n) !cs_act |=> !sdo_oe); // R9
  AST_OE_READ: assert property (@(posedge clk) disable iff (!rst_n) sdo_oe |-> (rw_q && cnt >= CW'(DATA_W))); // R4
  AST_SDO_FALL: assert property (@(posedge clk) disable iff (!rst_n) (cs_act && !fall) |=> $stable(sdo)); // R4
  AST_CFG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(rise && cs_act && !rw_q && cnt == CW'(FRAME - 1)) |=> $stable(cfg_out)); // R8
  AST_CNT_MAX: assert property (@(posedge clk) disable iff (!rst_n) cnt <= CW'(FRAME)); // R10
endmodule

// File: tb/tb_serial_cfg_port.sv
module tb_serial_cfg_port;
  logic clk = 0, rst_n = 0, cs_n = 1, sclk = 0, sdi = 0;
  logic [3:0] status_in = 0;
  logic sdo, sdo_oe;
  logic [23:0] cfg_out;
  logic [5:0] cfg_m [4];
  int checks = 0, errors = 0;
  bit done = 0;

  serial_cfg_port dut (.clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .sdi(sdi),
    .status_in(status_in), .sdo(sdo), .sdo_oe(sdo_oe), .cfg_out(cfg_out));

  always #4 clk = ~clk;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_read(input logic [4:0] a, input bit a5, input logic [3:0] st);
    if (a5) return 8'h00;
    if (a[2:0] == 3'b110) return {2'b00, cfg_m[a[4:3]]};
    if (a[2:0] == 3'b111) return {7'b0, st[a[4:3]]};
    return 8'h00;
  endfunction

  function automatic logic [23:0] exp_cfg();
    return {cfg_m[3], cfg_m[2], cfg_m[1], cfg_m[0]};
  endfunction

  task automatic half();
    repeat (8) @(negedge clk);
  endtask

  task automatic xfer(input bit rw, input logic [4:0] a, input bit a5, input bit a6,
                      input logic [7:0] wd, input int nbits, input int stop_at,
                      input bit same_edge, input bit flip,
                      output logic [7:0] rd, output bit oe_ok);
    logic [15:0] fr;
    int n;
    fr = {wd, a6, a5, a, rw};
    rd = 0;
    oe_ok = 1;
    n = (stop_at >= 0) ? stop_at : nbits;
    @(negedge clk);
    cs_n = 0; sclk = 0;
    half();
    for (int i = 0; i < n; i++) begin
      sdi = (i < 16) ? fr[i] : 1'($urandom % 2);
      half();
      if (i < 16 && sdo_oe !== (rw && i >= 8)) oe_ok = 0;
      if (i >= 8 && i < 16) rd[i-8] = sdo;
      if (i == 10 && flip) status_in = ~status_in;
      if (same_edge && i == n - 1) cs_n = 1;
      sclk = 1;
      half();
      sclk = 0;
    end
    half();
    cs_n = 1;
    half(); half();
  endtask

  task automatic run(input bit rw, input logic [4:0] a, input bit a5, input bit a6,
                     input logic [7:0] wd, input int nbits, input int stop_at,
                     input bit same_edge, input bit flip, input string req);
    logic [7:0] rd, er;
    bit ok;
    logic [3:0] st0;
    st0 = status_in;
    er = exp_read(a, a5, st0);
    xfer(rw, a, a5, a6, wd, nbits, stop_at, same_edge, flip, rd, ok);
    if (!rw && !a5 && a[2:0] == 3'b110 && stop_at < 0 && !same_edge) cfg_m[a[4:3]] = wd[5:0];
    if (rw && stop_at < 0) begin
      chk(rd == er, req, rd, er);
      chk(ok, {req, " oe timing"}, 0, 1);
    end
    chk(cfg_out == exp_cfg(), req, cfg_out, exp_cfg());
    chk(sdo_oe == 0, {req, " oe idle"}, sdo_oe, 0);
  endtask

  initial begin
    int unsigned r;
    r = $urandom(32'd4711);
    for (int c = 0; c < 4; c++) cfg_m[c] = 0;
    repeat (3) @(negedge clk);
    chk(cfg_out == 0 && sdo_oe == 0, "R1", {cfg_out, 7'b0, sdo_oe}, 0);
    rst_n = 1;
    repeat (3) @(negedge clk);
    chk(cfg_out == 0 && sdo_oe == 0, "R1", {cfg_out, 7'b0, sdo_oe}, 0);

    run(0, 5'h06, 0, 0, 8'h2A, 16, -1, 0, 0, "R3");
    run(0, 5'h0E, 0, 1, 8'hFF, 16, -1, 0, 0, "R2");
    run(1, 5'h0E, 0, 0, 8'h00, 16, -1, 0, 0, "R5");
    run(1, 5'h06, 0, 1, 8'h00, 16, -1, 0, 0, "R4");
    status_in = 4'b1010;
    run(1, 5'h0F, 0, 0, 8'h00, 16, -1, 0, 0, "R6");
    run(1, 5'h07, 0, 0, 8'h00, 16, -1, 0, 0, "R6");
    status_in = 4'b0100;
    run(1, 5'h17, 0, 0, 8'h00, 16, -1, 0, 1, "R6 capture");
    run(1, 5'h03, 0, 0, 8'h00, 16, -1, 0, 0, "R7");
    run(1, 5'h1D, 0, 0, 8'h00, 16, -1, 0, 0, "R7");
    run(0, 5'h07, 0, 0, 8'h15, 16, -1, 0, 0, "R8 status write");
    run(0, 5'h05, 0, 0, 8'h15, 16, -1, 0, 0, "R8 unmapped write");
    run(0, 5'h06, 1, 0, 8'h15, 16, -1, 0, 0, "R8 a5 write");
    run(1, 5'h06, 1, 0, 8'h00, 16, -1, 0, 0, "R8 a5 read");
    run(0, 5'h16, 0, 0, 8'h33, 16, 12, 0, 0, "R9 abort");
    run(0, 5'h1E, 0, 0, 8'h21, 16, -1, 1, 0, "R9 same edge");
    run(1, 5'h1E, 0, 0, 8'h00, 16, -1, 0, 0, "R9 readback");
    run(0, 5'h1E, 0, 0, 8'h1C, 21, -1, 0, 0, "R10");
    run(1, 5'h1E, 0, 0, 8'h00, 16, -1, 0, 0, "R10 readback");

    for (int k = 0; k < 90; k++) begin
      logic [4:0] a;
      bit rw, a5;
      status_in = 4'($urandom);
      a = ($urandom % 4 != 0) ? {2'($urandom), 2'b11, 1'($urandom)} : 5'($urandom);
      rw = 1'($urandom);
      a5 = ($urandom % 8 == 0);
      run(rw, a, a5, 1'($urandom), 8'($urandom), 16, -1, 0, 0, "R2 random");
    end
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule